// File: doc/BRIEF.md
# SPI Master Boot Image Fetcher

This block reads a boot image out of an external serial memory. It runs as an SPI master in mode 3 and copies the image into on-chip RAM. After `start` it works through a fixed list of read formats. Each format pairs a read opcode with a number of dummy bytes. A format is accepted when the two bytes that follow its dummy bytes form the signature 0x70, 0x50. If the signature is wrong, chip select is released, a short gap follows, and the next format is tried. If no format produces the signature, a sticky `fail` flag is raised.

Once a format is accepted, the block reads a short header that holds an extension flag and a 16-bit length. It then streams the code bytes and packs them little-endian into 32-bit words, which it writes to consecutive RAM word addresses from zero. `done` marks the end of the copy. A half-period divider sets the SCK rate. The size that the extension flag adds is a parameter, which defaults to 64 KB.

Top module: `spi_boot_fetch`

## Requirements
- R1: After reset, and until `start`, `spi_cs_n` is 1, `spi_sck` is 1, `ram_we` is 0, and `done` and `fail` are 0.
- R2: SCK idles high whenever chip select is high. Each byte is 8 SCK cycles. MOSI is shifted out MSB first and changes on falling edges. MISO is sampled on rising edges.
- R3: Each attempt lowers `spi_cs_n` and sends an opcode byte, then two 0x00 address bytes, then its dummy bytes, all 0x00. The attempt order is: 0x03 with 0 dummies, 0x03 with 1, 0x0B with 2, then 0xE8 with 5.
- R4: The first byte after the dummy bytes must be 0x70 and the second must be 0x50. A mismatch in either byte ends the attempt at once: CS rises, stays high for at least GAP_CYCLES clocks, and the next attempt starts.
- R5: If all four attempts fail, `fail` rises and stays at 1 until the next `start`, with no RAM write and CS held high.
- R6: After the signature, three bytes are ignored. The next three bytes are the extension byte, the length high byte and the length low byte. MOSI stays 0x00 for every byte after the opcode. CS stays low without a break from the opcode to the last code byte.
- R7: If the extension byte equals 0x01, the image length in bytes is EXT_BYTES plus the 16-bit length. For any other extension value it is the 16-bit length alone.
- R8: Code byte k lands in word address k/4, in bits 8*(k mod 4)+7 down to 8*(k mod 4). Words are written in increasing address order starting at 0, with one write per word.
- R9: The last word is written with its unused upper bytes set to 0. `done` rises in the same cycle as the last write, with CS high. A length of 0 gives `done` with no write.
- R10: `done` and `fail` are never high together, and a new `start` clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a fetch when the block is idle, done or failed |
| spi_sck | output | 1 | SPI clock, idles high |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the memory |
| spi_miso | input | 1 | Serial data from the memory |
| ram_we | output | 1 | RAM word write strobe |
| ram_addr | output | RAM_AW | RAM word address |
| ram_wdata | output | 32 | RAM write word, little-endian byte packing |
| done | output | 1 | Image copied; held until next start |
| fail | output | 1 | No read format matched; held until next start |

## Verification
A wrong attempt index shows at the pins within the next opcode byte: the bench compares the opcode of every chip-select session with the required order. A header counter that is off by one shifts the signature window, so the attempt aborts one byte early or late, and shifts every length and code byte, so the first RAM word write carries a wrong word. Packing or length errors show on the first or last write. Each write is compared in the cycle it occurs with the next word that the bench expects. The bench also checks that `done` coincides with the last write and that no writes are missing.

// File: rtl/boot_fetch_pkg.sv
package boot_fetch_pkg;

    localparam int NUM_TRIES = 4;

    typedef enum logic [3:0] {
        ST_IDLE, ST_HDR, ST_SIG0, ST_SIG1, ST_SKIP, ST_EXT,
        ST_LENH, ST_LENL, ST_DATA, ST_GAP, ST_DONE, ST_FAIL
    } fetch_state_e;

    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} sck_phase_e;

    function automatic logic [7:0] try_opcode(input logic [1:0] att);
        case (att)
            2'd0, 2'd1: try_opcode = 8'h03;
            2'd2:       try_opcode = 8'h0B;
            default:    try_opcode = 8'hE8;
        endcase
    endfunction

    function automatic logic [2:0] try_dummies(input logic [1:0] att);
        case (att)
            2'd0:    try_dummies = 3'd0;
            2'd1:    try_dummies = 3'd1;
            2'd2:    try_dummies = 3'd2;
            default: try_dummies = 3'd5;
        endcase
    endfunction

endpackage

// File: rtl/boot_spi_byte.sv
module boot_spi_byte
    import boot_fetch_pkg::*;
#(
    parameter int HALF_PERIOD = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       rx_done,
    output logic [7:0] rx_byte
);

    localparam int CW = $clog2(HALF_PERIOD + 1);

    typedef struct packed {
        sck_phase_e    phase;
        logic [CW-1:0] cnt;
        logic [2:0]    bitn;
        logic [7:0]    sh;
        logic [7:0]    rx;
        logic          done;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.phase)
            PH_IDLE: begin
                if (go) begin
                    d.sh    = tx_byte;
                    d.bitn  = '0;
                    d.cnt   = '0;
                    d.phase = PH_LOW;
                end
            end
            PH_LOW: begin
                if (q.cnt == CW'(HALF_PERIOD - 1)) begin
                    d.cnt   = '0;
                    d.phase = PH_HIGH;
                    d.rx    = {q.rx[6:0], miso};
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: begin
                if (q.cnt == CW'(HALF_PERIOD - 1)) begin
                    d.cnt = '0;
                    if (q.bitn == 3'd7) begin
                        d.phase = PH_IDLE;
                        d.done  = 1'b1;
                    end else begin
                        d.bitn  = q.bitn + 1'b1;
                        d.sh    = {q.sh[6:0], 1'b0};
                        d.phase = PH_LOW;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, cnt: '0, bitn: '0, sh: '0, rx: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sck     = (q.phase != PH_LOW);
    assign mosi    = q.sh[7];
    assign rx_done = q.done;
    assign rx_byte = q.rx;

endmodule

// File: rtl/boot_word_packer.sv
module boot_word_packer #(
    parameter int RAM_AW = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              byte_v,
    input  logic [7:0]        byte_in,
    input  logic              last,
    output logic              we,
    output logic [RAM_AW-1:0] addr,
    output logic [31:0]       wdata
);

    typedef struct packed {
        logic [1:0]        lane;
        logic [31:0]       word;
        logic [RAM_AW-1:0] ptr;
        logic              we;
        logic [RAM_AW-1:0] waddr;
        logic [31:0]       wdata;
    } pack_t;

    pack_t q, d;
    logic [31:0] merged;

    always_comb begin
        d      = q;
        d.we   = 1'b0;
        merged = q.word;
        merged[{q.lane, 3'b000} +: 8] = byte_in;
        if (clear) begin
            d.lane = '0;
            d.word = '0;
            d.ptr  = '0;
        end else if (byte_v) begin
            if (q.lane == 2'd3 || last) begin
                d.we    = 1'b1;
                d.wdata = merged;
                d.waddr = q.ptr;
                d.ptr   = q.ptr + 1'b1;
                d.word  = '0;
                d.lane  = '0;
            end else begin
                d.word = merged;
                d.lane = q.lane + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign we    = q.we;
    assign addr  = q.waddr;
    assign wdata = q.wdata;

endmodule

// File: rtl/spi_boot_fetch.sv
module spi_boot_fetch
    import boot_fetch_pkg::*;
#(
    parameter int HALF_PERIOD = 2,
    parameter int GAP_CYCLES  = 4,
    parameter int EXT_BYTES   = 65536,
    parameter int RAM_AW      = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [31:0]       ram_wdata,
    output logic              done,
    output logic              fail
);

    localparam int LEN_W = $clog2(EXT_BYTES + 65536);
    localparam int GW    = $clog2(GAP_CYCLES + 1);

    typedef struct packed {
        fetch_state_e   st;
        logic [1:0]     att;
        logic [3:0]     idx;
        logic [7:0]     len_hi;
        logic           ext;
        logic [LEN_W-1:0] remain;
        logic [GW-1:0]  gap;
        logic           go;
        logic [7:0]     tx;
        logic           cs_n;
        logic           done;
        logic           fail;
    } ctl_t;

    ctl_t q, d;

    logic             rx_done;
    logic [7:0]       rx_byte;
    logic             launch;
    logic             byte_v;
    logic             last_byte;
    logic [LEN_W-1:0] full_len;

    assign launch    = start && (q.st == ST_IDLE || q.st == ST_DONE || q.st == ST_FAIL);
    assign byte_v    = rx_done && (q.st == ST_DATA);
    assign last_byte = (q.remain == LEN_W'(1));
    assign full_len  = LEN_W'({q.len_hi, rx_byte}) + (q.ext ? LEN_W'(EXT_BYTES) : '0);

    always_comb begin
        d    = q;
        d.go = 1'b0;
        if (launch) begin
            d.att  = '0;
            d.idx  = '0;
            d.cs_n = 1'b0;
            d.go   = 1'b1;
            d.tx   = try_opcode(2'd0);
            d.st   = ST_HDR;
            d.done = 1'b0;
            d.fail = 1'b0;
        end else begin
            case (q.st)
                ST_HDR: if (rx_done) begin
                    d.go = 1'b1;
                    d.tx = 8'h00;
                    if (q.idx == 4'd2 + {1'b0, try_dummies(q.att)}) begin
                        d.st = ST_SIG0;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
                ST_SIG0, ST_SIG1: if (rx_done) begin
                    if (rx_byte == ((q.st == ST_SIG0) ? 8'h70 : 8'h50)) begin
                        d.go  = 1'b1;
                        d.idx = '0;
                        d.st  = (q.st == ST_SIG0) ? ST_SIG1 : ST_SKIP;
                    end else begin
                        d.cs_n = 1'b1;
                        d.gap  = '0;
                        if (q.att == 2'(NUM_TRIES - 1)) begin
                            d.st   = ST_FAIL;
                            d.fail = 1'b1;
                        end else begin
                            d.att = q.att + 1'b1;
                            d.st  = ST_GAP;
                        end
                    end
                end
                ST_SKIP: if (rx_done) begin
                    d.go = 1'b1;
                    if (q.idx == 4'd2) d.st = ST_EXT;
                    else               d.idx = q.idx + 1'b1;
                end
                ST_EXT: if (rx_done) begin
                    d.ext = (rx_byte == 8'h01);
                    d.go  = 1'b1;
                    d.st  = ST_LENH;
                end
                ST_LENH: if (rx_done) begin
                    d.len_hi = rx_byte;
                    d.go     = 1'b1;
                    d.st     = ST_LENL;
                end
                ST_LENL: if (rx_done) begin
                    if (full_len == '0) begin
                        d.cs_n = 1'b1;
                        d.done = 1'b1;
                        d.st   = ST_DONE;
                    end else begin
                        d.remain = full_len;
                        d.go     = 1'b1;
                        d.st     = ST_DATA;
                    end
                end
                ST_DATA: if (rx_done) begin
                    if (last_byte) begin
                        d.cs_n = 1'b1;
                        d.done = 1'b1;
                        d.st   = ST_DONE;
                    end else begin
                        d.remain = q.remain - 1'b1;
                        d.go     = 1'b1;
                    end
                end
                ST_GAP: begin
                    if (q.gap == GW'(GAP_CYCLES - 1)) begin
                        d.cs_n = 1'b0;
                        d.idx  = '0;
                        d.go   = 1'b1;
                        d.tx   = try_opcode(q.att);
                        d.st   = ST_HDR;
                    end else begin
                        d.gap = q.gap + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, att: '0, idx: '0, len_hi: '0, ext: 1'b0,
                   remain: '0, gap: '0, go: 1'b0, tx: '0, cs_n: 1'b1,
                   done: 1'b0, fail: 1'b0};
        end else begin
            q <= d;
        end
    end

    boot_spi_byte #(.HALF_PERIOD(HALF_PERIOD)) i_byte (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (q.go),
        .tx_byte (q.tx),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .rx_done (rx_done),
        .rx_byte (rx_byte)
    );

    boot_word_packer #(.RAM_AW(RAM_AW)) i_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (launch),
        .byte_v  (byte_v),
        .byte_in (rx_byte),
        .last    (last_byte),
        .we      (ram_we),
        .addr    (ram_addr),
        .wdata   (ram_wdata)
    );

    assign spi_cs_n = q.cs_n;
    assign done     = q.done;
    assign fail     = q.fail;

endmodule

// File: rtl/boot_fetch_chk.sv
module boot_fetch_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic spi_cs_n,
    input logic spi_sck,
    input logic ram_we,
    input logic done,
    input logic fail
);

    // R2
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> spi_sck);

    // R10
    done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    // R5
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> fail);

    // R5
    fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (spi_cs_n && !ram_we));

    // R9
    done_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> spi_cs_n);

endmodule

bind spi_boot_fetch boot_fetch_chk i_fetch_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .spi_cs_n (spi_cs_n),
    .spi_sck  (spi_sck),
    .ram_we   (ram_we),
    .done     (done),
    .fail     (fail)
);

// File: tb/test_spi_boot_fetch.sv
module test_spi_boot_fetch;

    localparam int HP    = 1;
    localparam int GAP   = 3;
    localparam int EXTB  = 16;
    localparam int AW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          spi_sck, spi_cs_n, spi_mosi;
    logic          spi_miso = 1'b1;
    logic          ram_we;
    logic [AW-1:0] ram_addr;
    logic [31:0]   ram_wdata;
    logic          done, fail;

    always #2 clk = ~clk;

    spi_boot_fetch #(.HALF_PERIOD(HP), .GAP_CYCLES(GAP), .EXT_BYTES(EXTB), .RAM_AW(AW)) i_spi_boot_fetch (
        .clk(clk), .rst_n(rst_n), .start(start),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .done(done), .fail(fail)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // required attempt order
    logic [7:0] ref_op  [4] = '{8'h03, 8'h03, 8'h0B, 8'hE8};
    int         ref_dum [4] = '{0, 1, 2, 5};

    // memory model state
    int         acc_idx = -1;
    logic [7:0] stream [64];
    int         sess = 0;
    int         bitc = 0;
    int         bytec = 0;
    logic [7:0] shreg = 0;
    logic [7:0] ops [8];
    int         mosi_nz = 0;
    longint     cyc = 0;
    longint     cs_rise = 0;

    function automatic logic [7:0] resp(input int att, input int b);
        int hdr;
        hdr = 3 + ((att >= 0 && att < 4) ? ref_dum[att] : 0);
        if (att == acc_idx && b >= hdr && (b - hdr) < 64) return stream[b - hdr];
        return 8'hFF;
    endfunction

    always @(posedge clk) cyc++;

    always @(posedge spi_cs_n) cs_rise = cyc;

    always @(negedge spi_cs_n) begin
        if (sess > 0) chk((cyc - cs_rise) >= GAP, "R4", "cs high gap", cyc - cs_rise, GAP);
        sess++;
        bitc = 0;
        bytec = 0;
    end

    always @(negedge spi_sck) if (!spi_cs_n) begin
        logic [7:0] rb;
        rb = resp(sess - 1, bytec);
        spi_miso = rb[7 - bitc];
    end

    always @(posedge spi_sck) if (!spi_cs_n) begin
        shreg = {shreg[6:0], spi_mosi};
        bitc++;
        if (bitc == 8) begin
            if (bytec == 0) begin
                if (sess >= 1 && sess <= 8) ops[sess - 1] = shreg;
            end else if (shreg != 8'h00) begin
                mosi_nz++;
            end
            bitc = 0;
            bytec++;
        end
    end

    // reference of RAM writes
    logic [31:0] expq [$];
    int          wcnt = 0;
    bit          prev_done = 0;
    bit          mon_on = 0;

    always @(negedge clk) if (mon_on) begin
        if (spi_cs_n) chk(spi_sck == 1'b1, "R2", "sck idle level", spi_sck, 1);
        if (ram_we) begin
            if (expq.size() == 0) begin
                chk(0, "R8", "unexpected write", ram_addr, 0);
            end else begin
                chk(ram_addr == AW'(wcnt), "R8", "write address", ram_addr, wcnt);
                chk(ram_wdata == expq[0], "R8", "write data", ram_wdata, expq[0]);
                void'(expq.pop_front());
                wcnt++;
            end
        end
        if (done && !prev_done && wcnt > 0)
            chk(ram_we == 1'b1, "R9", "done with last write", ram_we, 1);
        prev_done = done;
    end

    task automatic run_case(input string name, input int acc, input logic [7:0] sig1,
                            input logic [7:0] ext, input logic [7:0] lh, input logic [7:0] ll,
                            input bit expect_ok);
        int len;
        int nw;
        int waited;
        logic [7:0] code [48];
        len = {lh, ll} + ((ext == 8'h01) ? EXTB : 0);
        for (int i = 0; i < 48; i++) code[i] = 8'(i * 37 + 11);
        for (int i = 0; i < 64; i++) stream[i] = 8'h00;
        stream[0] = 8'h70; stream[1] = sig1;
        stream[2] = 8'h70; stream[3] = 8'h50; stream[4] = 8'h01;
        stream[5] = ext; stream[6] = lh; stream[7] = ll;
        for (int i = 0; i < len && i < 48; i++) stream[8 + i] = code[i];
        acc_idx = acc;
        sess = 0;
        mosi_nz = 0;
        wcnt = 0;
        expq.delete();
        nw = expect_ok ? (len + 3) / 4 : 0;
        for (int w = 0; w < nw; w++) begin
            logic [31:0] word;
            word = 0;
            for (int b = 0; b < 4; b++)
                if (w * 4 + b < len) word[b*8 +: 8] = code[w * 4 + b];
            expq.push_back(word);
        end
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && fail == 1'b0, "R10", {name, " flags cleared by start"}, {done, fail}, 0);
        waited = 0;
        while (!(done || fail) && waited < 40000) begin
            @(negedge clk);
            waited++;
        end
        chk(waited < 40000, "R9", {name, " watchdog"}, waited, 40000);
        repeat (3) @(negedge clk);
        chk(done == expect_ok, "R9", {name, " done"}, done, expect_ok);
        chk(fail == !expect_ok, "R5", {name, " fail"}, fail, !expect_ok);
        chk(expq.size() == 0, "R8", {name, " all words written"}, expq.size(), 0);
        chk(wcnt == nw, "R7", {name, " word count"}, wcnt, nw);
        chk(mosi_nz == 0, "R6", {name, " mosi zero after opcode"}, mosi_nz, 0);
        chk(sess == (expect_ok ? acc + 1 : 4), "R3", {name, " attempt count"}, sess, expect_ok ? acc + 1 : 4);
        for (int s = 0; s < sess && s < 4; s++)
            chk(ops[s] == ref_op[s], "R3", {name, " opcode order"}, ops[s], ref_op[s]);
        if (!expect_ok) begin
            repeat (20) @(negedge clk);
            chk(fail == 1'b1 && spi_cs_n == 1'b1, "R5", {name, " fail held"}, {fail, spi_cs_n}, 2'b11);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1'b1 && spi_sck == 1'b1, "R1", "reset pins", {spi_cs_n, spi_sck}, 2'b11);
        chk(ram_we == 1'b0 && done == 1'b0 && fail == 1'b0, "R1", "reset outputs", {ram_we, done, fail}, 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (5) @(negedge clk);
        chk(spi_cs_n == 1'b1 && done == 1'b0, "R1", "idle before start", {spi_cs_n, done}, 2'b10);
        // R2 R6 R8 R9: first format, partial last word
        run_case("A", 0, 8'h50, 8'h00, 8'h00, 8'h05, 1);
        // R3 R4: third format
        run_case("B", 2, 8'h50, 8'h00, 8'h00, 8'h08, 1);
        // R7: extension adds EXT_BYTES on last format
        run_case("C", 3, 8'h50, 8'h01, 8'h00, 8'h03, 1);
        // R5: nothing answers
        run_case("D", -1, 8'h50, 8'h00, 8'h00, 8'h04, 0);
        // R4: second signature byte wrong
        run_case("E", 1, 8'h51, 8'h00, 8'h00, 8'h04, 0);
        // R7: extension value other than 1 is ignored
        run_case("F", 0, 8'h50, 8'h02, 8'h00, 8'h02, 1);
        // R9: zero length
        run_case("G", 1, 8'h50, 8'h00, 8'h00, 8'h00, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL R9 global watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule